// File: doc/BRIEF.md
# Watchdog Timer with Safe-Frequency Fallback

This block is the watchdog part of a programmable clock generator. Software starts the watchdog by writing a control byte. A prescaled timebase then counts down a fixed number of ticks. If software does not restart or stop the watchdog before the count runs out, the block raises a sticky timeout flag. If fallback is armed, the block also copies a stored 5-bit safe frequency code into the frequency-select register, which drives the synthesizer.

The register port is byte wide. Writes are sampled on the rising clock edge, and reads return combinationally from the address. There are three mapped registers. The frequency register (address 0) holds the fallback-arm bit in bit 7 and the frequency code in bits 4:0. The control register (address 1) holds the auxiliary output select in bit 7, the run/enable bit in bit 6, the timeout flag in bit 5 and the safe code in bits 4:0. The identity register (address 2) is read-only. The auxiliary output select picks 24 MHz when it is 1 and 48 MHz when it is 0. Its value after reset is taken from a strap pin.

The countdown lasts `PRESCALE_DIV * TIMEOUT_TICKS` clock cycles, counted from the clock edge that samples the starting write.

Top module: `wdog_safe_freq`

## Requirements
- R1: After reset, the control register reads {strap, 0, 0, 5'b00010}, the frequency register reads 00h and `freq_code` is 0.
- R2: Control bit 7 is writable and drives `sel_24m` (1 = 24 MHz, 0 = 48 MHz). Its value after reset equals the `strap_sel24` pin.
- R3: A control write with bit 6 = 1 loads the full countdown, clears the timeout flag and makes bit 6 read 1. The same write made while the watchdog is counting reloads the countdown.
- R4: The timeout occurs `PRESCALE_DIV*TIMEOUT_TICKS` edges after the edge that sampled the starting write. From then on, control bit 6 reads 0 and bit 5 reads 1. One edge earlier, bit 6 still reads 1.
- R5: A control write with bit 6 = 0 stops the countdown, so no timeout follows. The timeout flag keeps its value.
- R6: Control bit 5 (timeout flag) is read-only, and writes to it are ignored.
- R7: When frequency bit 7 = 1 at timeout, frequency bits 4:0 take the safe code. This load wins over a frequency-register write in the same cycle, but that write still sets bit 7.
- R8: When frequency bit 7 = 0 at timeout, frequency bits 4:0 are unchanged.
- R9: Address 2 always reads 60h, and writes to it are ignored. Address 3 reads 00h.
- R10: After a timeout, the flag stays at 1, bit 6 stays at 0 and the frequency register holds its value until the next start.
- R11: Frequency register bits 6:5 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_sel24 | input | 1 | Strap value for the output-select reset state |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| freq_code | output | 5 | Frequency-select code to the synthesizer |
| sel_24m | output | 1 | Auxiliary output select, 1 = 24 MHz |

## Verification
Read data is combinational, so a register write can be seen from the half cycle after the edge that samples it. The bench drives each write at a falling edge and reads back at the next falling edge. The timeout is due exactly `PRESCALE_DIV*TIMEOUT_TICKS` edges after the starting write. The bench counts falling edges from that write and checks the last cycle before expiry, then the first cycle after it. The collision case puts a frequency write on the expiry edge itself by counting one edge fewer.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // register map
  localparam logic [1:0] ADDR_FREQ = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_ID   = 2'd2;

  // control byte bit positions
  localparam int unsigned CTRL_SEL_BIT  = 7;
  localparam int unsigned CTRL_RUN_BIT  = 6;
  localparam int unsigned CTRL_FLAG_BIT = 5;

  // frequency byte bit positions
  localparam int unsigned FREQ_FB_BIT = 7;

  localparam int unsigned CODE_W = 5;

  localparam logic [CODE_W-1:0] SAFE_RST = 5'b00010;

  // identity fields
  localparam logic [1:0] ID_MASTER    = 2'b01;
  localparam logic [1:0] ID_SUB       = 2'b10;
  localparam logic [1:0] ID_MASTER_RV = 2'b00;
  localparam logic [1:0] ID_SUB_RV    = 2'b00;
  localparam logic [7:0] ID_VALUE     = {ID_MASTER, ID_SUB, ID_MASTER_RV, ID_SUB_RV};

  typedef struct packed {
    logic start;
    logic stop;
  } wd_cmd_t;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_out = stage2_q;

endmodule

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);

  localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);
  localparam logic [PRE_W-1:0] STEP = PRE_W'(1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic             pre_en;

  assign tick = run && (pre_q == LAST);

  always_comb begin
    pre_en = clear || run;
    if (clear) begin
      pre_d = '0;
    end else if (tick) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_en) begin
      pre_q <= pre_d;
    end
  end

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned TICKS = 5,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             tick,
  output logic             running,
  output logic             flag,
  output logic             expire,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LOAD = CNT_W'(TICKS);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             flag_q, flag_d;
  logic             upd_en;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    flag_d = flag_q;
    expire = 1'b0;
    upd_en = start || stop || (run_q && tick);
    if (start) begin
      cnt_d  = LOAD;
      run_d  = 1'b1;
      flag_d = 1'b0;
    end else if (stop) begin
      run_d = 1'b0;
    end else if (run_q && tick) begin
      if (cnt_q == ONE) begin
        cnt_d  = '0;
        run_d  = 1'b0;
        flag_d = 1'b1;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign running = run_q;
  assign flag    = flag_q;
  assign cnt     = cnt_q;

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap,
  input  logic [1:0]        addr,
  input  logic              wr,
  input  logic [7:0]        wdata,
  input  logic              expire,
  input  logic              running,
  input  logic              flag,
  output wd_cmd_t           cmd,
  output logic [7:0]        rdata,
  output logic [CODE_W-1:0] freq_code,
  output logic [CODE_W-1:0] safe_code,
  output logic              fb_en,
  output logic              sel_24m
);

  logic              wr_freq, wr_ctrl;
  logic              fb_q, fb_d;
  logic [CODE_W-1:0] freq_q, freq_d;
  logic [CODE_W-1:0] safe_q, safe_d;
  logic              sel_q, sel_d;
  logic              pend_q;
  logic              freq_en, ctrl_en, sel_en;
  logic              sel_eff;
  logic              wdata_unused;

  assign wdata_unused = wdata[CTRL_FLAG_BIT];

  assign wr_freq = wr && (addr == ADDR_FREQ);
  assign wr_ctrl = wr && (addr == ADDR_CTRL);

  always_comb begin
    cmd.start = wr_ctrl &&  wdata[CTRL_RUN_BIT];
    cmd.stop  = wr_ctrl && !wdata[CTRL_RUN_BIT];
  end

  // frequency register: software write, then fallback load on top
  always_comb begin
    fb_d    = fb_q;
    freq_d  = freq_q;
    freq_en = wr_freq || (expire && fb_q);
    if (wr_freq) begin
      fb_d   = wdata[FREQ_FB_BIT];
      freq_d = wdata[CODE_W-1:0];
    end
    if (expire && fb_q) begin
      freq_d = safe_q;
    end
  end

  // control register writable fields
  always_comb begin
    ctrl_en = wr_ctrl;
    safe_d  = wdata[CODE_W-1:0];
    sel_en  = wr_ctrl || pend_q;
    if (wr_ctrl) begin
      sel_d = wdata[CTRL_SEL_BIT];
    end else begin
      sel_d = strap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q   <= 1'b0;
      freq_q <= '0;
    end else if (freq_en) begin
      fb_q   <= fb_d;
      freq_q <= freq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      safe_q <= SAFE_RST;
    end else if (ctrl_en) begin
      safe_q <= safe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
    end else begin
      pend_q <= 1'b0;
    end
  end

  assign sel_eff = pend_q ? strap : sel_q;

  always_comb begin
    case (addr)
      ADDR_FREQ: rdata = {fb_q, 2'b00, freq_q};
      ADDR_CTRL: rdata = {sel_eff, running, flag, safe_q};
      ADDR_ID:   rdata = ID_VALUE;
      default:   rdata = 8'h00;
    endcase
  end

  assign freq_code = freq_q;
  assign safe_code = safe_q;
  assign fb_en     = fb_q;
  assign sel_24m   = sel_eff;

endmodule

// File: rtl/wdog_safe_freq.sv
module wdog_safe_freq
  import wdog_pkg::*;
#(
  parameter int unsigned PRESCALE_DIV  = 4,
  parameter int unsigned TIMEOUT_TICKS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_sel24,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic [4:0]  freq_code,
  output logic        sel_24m
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT_TICKS + 1);

  logic              rst_sync_n;
  wd_cmd_t           cmd;
  logic              wd_start, wd_stop;
  logic              wd_tick, wd_run, wd_flag, wd_expire;
  logic [CNT_W-1:0]  wd_cnt;
  logic [CODE_W-1:0] safe_code;
  logic              fb_en;

  assign wd_start = cmd.start;
  assign wd_stop  = cmd.stop;

  wdog_rst_sync rst_sync_i (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  wdog_tick_gen #(.DIV(PRESCALE_DIV)) tick_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clear (wd_start),
    .run   (wd_run),
    .tick  (wd_tick)
  );

  wdog_count #(.TICKS(TIMEOUT_TICKS), .CNT_W(CNT_W)) count_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (wd_start),
    .stop    (wd_stop),
    .tick    (wd_tick),
    .running (wd_run),
    .flag    (wd_flag),
    .expire  (wd_expire),
    .cnt     (wd_cnt)
  );

  wdog_regs regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .strap     (strap_sel24),
    .addr      (reg_addr),
    .wr        (reg_wr),
    .wdata     (reg_wdata),
    .expire    (wd_expire),
    .running   (wd_run),
    .flag      (wd_flag),
    .cmd       (cmd),
    .rdata     (reg_rdata),
    .freq_code (freq_code),
    .safe_code (safe_code),
    .fb_en     (fb_en),
    .sel_24m   (sel_24m)
  );

endmodule

// File: rtl/wdog_safe_freq_chk.sv
module wdog_safe_freq_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic             tick,
  input logic             run,
  input logic             flag,
  input logic             expire,
  input logic [CNT_W-1:0] cnt,
  input logic             fb_en,
  input logic [4:0]       safe_code,
  input logic [4:0]       freq_code,
  input logic [1:0]       addr,
  input logic             wr,
  input logic [7:0]       rdata
);

  // R3
  start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run && !flag && (cnt != '0)));

  // R4
  expiry_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && (cnt == CNT_W'(1)) && !start && !stop) |=> (flag && !run));

  // R4
  run_flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && flag));

  // R5
  stop_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!run && (flag == $past(flag))));

  // R7
  fallback_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && fb_en) |=> (freq_code == $past(safe_code)));

  // R8
  no_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !fb_en && !(wr && addr == 2'd0)) |=> $stable(freq_code));

  // R10
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !start) |=> (flag && (cnt == '0)));

  // R9
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd2) |-> (rdata == 8'h60));

endmodule

bind wdog_safe_freq wdog_safe_freq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (wd_start),
  .stop      (wd_stop),
  .tick      (wd_tick),
  .run       (wd_run),
  .flag      (wd_flag),
  .expire    (wd_expire),
  .cnt       (wd_cnt),
  .fb_en     (fb_en),
  .safe_code (safe_code),
  .freq_code (freq_code),
  .addr      (reg_addr),
  .wr        (reg_wr),
  .rdata     (reg_rdata)
);

// File: tb/wdog_safe_freq_tb_top.sv
module wdog_safe_freq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PRE        = 4;
  localparam int TICKS      = 5;
  localparam int NP         = PRE * TICKS;

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] addr;
    logic       wr;
    logic [7:0] wdata;
    logic [7:0] exp;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [0:NVEC-1] = '{
    {4'd1,  2'd1, 1'b0, 8'h00, 8'h82},  // R1 control reset, strap = 1
    {4'd1,  2'd0, 1'b0, 8'h00, 8'h00},  // R1 frequency reset
    {4'd9,  2'd2, 1'b0, 8'h00, 8'h60},  // R9 identity
    {4'd9,  2'd3, 1'b0, 8'h00, 8'h00},  // R9 unmapped
    {4'd11, 2'd0, 1'b1, 8'hFF, 8'h9F},  // R11 bits 6:5 stay 0
    {4'd11, 2'd0, 1'b1, 8'h0A, 8'h0A},  // R11 plain write
    {4'd9,  2'd2, 1'b1, 8'h13, 8'h60},  // R9 write ignored
    {4'd6,  2'd1, 1'b1, 8'h3F, 8'h1F},  // R6 flag bit not writable
    {4'd2,  2'd1, 1'b1, 8'h85, 8'h85}   // R2 select bit writable
  };

  logic       clk;
  logic       rst_n;
  logic       strap_sel24;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [4:0] freq_code;
  logic       sel_24m;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  wdog_safe_freq #(.PRESCALE_DIV(PRE), .TIMEOUT_TICKS(TICKS)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_sel24 (strap_sel24),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .freq_code   (freq_code),
    .sel_24m     (sel_24m)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; the write is sampled at the next rising edge
  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic read_check(input string req, input string what,
                            input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, what, reg_rdata, exp);
  endtask

  task automatic apply_reset(input logic strap);
    @(negedge clk);
    rst_n       = 1'b0;
    strap_sel24 = strap;
    reg_wr      = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R4 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    strap_sel24 = 1'b1;
    reg_addr    = 2'd0;
    reg_wr      = 1'b0;
    reg_wdata   = 8'h00;
    apply_reset(1'b1);

    // R1 R2 reset outputs
    check("R2", "sel_24m after reset, strap=1", {7'd0, sel_24m}, 8'h01);
    check("R1", "freq_code after reset", {3'd0, freq_code}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].wr) do_write(VEC[i].addr, VEC[i].wdata);
      read_check($sformatf("R%0d", VEC[i].req), $sformatf("vector %0d", i),
                 VEC[i].addr, VEC[i].exp);
    end
    check("R2", "sel_24m after writing 1", {7'd0, sel_24m}, 8'h01);

    // R3 R4 R7 expiry with fallback armed
    do_write(2'd0, 8'h8A);
    do_write(2'd1, 8'h45);
    read_check("R3", "running after start", 2'd1, 8'h45);
    check("R2", "sel_24m after writing 0", {7'd0, sel_24m}, 8'h00);
    repeat (NP - 1) @(negedge clk);
    read_check("R4", "last cycle before expiry", 2'd1, 8'h45);
    read_check("R7", "freq before expiry", 2'd0, 8'h8A);
    @(negedge clk);
    read_check("R4", "first cycle after expiry", 2'd1, 8'h25);
    read_check("R7", "fallback loaded", 2'd0, 8'h85);
    check("R7", "freq_code port after fallback", {3'd0, freq_code}, 8'h05);

    // R10 state held after timeout
    repeat (30) @(negedge clk);
    read_check("R10", "flag held", 2'd1, 8'h25);
    read_check("R10", "freq held", 2'd0, 8'h85);

    // R3 restart clears flag, rewrite reloads
    do_write(2'd1, 8'h46);
    read_check("R3", "restart clears flag", 2'd1, 8'h46);
    repeat (10) @(negedge clk);
    do_write(2'd1, 8'h46);
    repeat (NP - 1) @(negedge clk);
    read_check("R3", "reload extends countdown", 2'd1, 8'h46);
    @(negedge clk);
    read_check("R4", "expiry after reload", 2'd1, 8'h26);
    read_check("R7", "fallback after reload", 2'd0, 8'h86);

    // R8 fallback disarmed
    do_write(2'd0, 8'h03);
    do_write(2'd1, 8'h47);
    repeat (NP) @(negedge clk);
    read_check("R8", "expiry without fallback", 2'd1, 8'h27);
    read_check("R8", "freq unchanged", 2'd0, 8'h03);

    // R5 stop with flag set keeps flag
    do_write(2'd1, 8'h07);
    read_check("R5", "stop keeps flag", 2'd1, 8'h27);

    // R5 stop during countdown prevents expiry
    do_write(2'd1, 8'h41);
    read_check("R5", "started", 2'd1, 8'h41);
    repeat (5) @(negedge clk);
    do_write(2'd1, 8'h01);
    read_check("R5", "stopped", 2'd1, 8'h01);
    repeat (3 * NP) @(negedge clk);
    read_check("R5", "no expiry after stop", 2'd1, 8'h01);

    // R7 write on the expiry edge
    do_write(2'd0, 8'h81);
    do_write(2'd1, 8'h49);
    repeat (NP - 1) @(negedge clk);
    do_write(2'd0, 8'h9E);
    read_check("R7", "fallback wins over same-cycle write", 2'd0, 8'h89);
    read_check("R4", "flag at collision", 2'd1, 8'h29);

    // R1 R2 reset mid-run with strap = 0
    do_write(2'd1, 8'hC1);
    apply_reset(1'b0);
    read_check("R1", "control after second reset", 2'd1, 8'h02);
    read_check("R1", "freq after second reset", 2'd0, 8'h00);
    check("R2", "sel_24m after reset, strap=0", {7'd0, sel_24m}, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule